// File: doc/BRIEF.md
# Character Display Instruction Decoder

This block sits behind the bus front end of a character display controller and interprets instruction-register writes. A write is one clock cycle of `wr_en` with `rs` low and an 8-bit `code`. Three commands are recognised. The configuration command sets the bus width, the display addressing scheme, the line layout and the driver pin arrangement. The glyph-memory address command and the text-memory address command each load a shared address counter and tag it with the memory that later data transfers will reach. All other codes leave the block untouched.

Control is a two-state machine. `ST_AWAIT_FSET` is the state after reset; in it only the configuration command is honoured. The transition `FIRST_CONFIG`, taken on that command, leads to `ST_READY`. In `ST_READY`, the transition `RECONFIG` is a self-loop taken when a configuration command carries a bus-width bit that differs from the stored one. Every other configuration command in `ST_READY` is dropped. Text-memory addresses outside the legal window of the current addressing scheme are also dropped. A registered `accepted` pulse reports, one edge after each write, whether that write took effect.

Top module: `cdisp_instr_decoder`

## Requirements
- R1: After reset, `if_8bit`=1, `addr_mode2`=0, `two_line`=0, `pin_mode_b`=0, `ac`=0, `ac_is_cg`=0 and `accepted`=0, and the machine is in `ST_AWAIT_FSET`.
- R2: The configuration command is any code with bits 7:6 = 00 and bit 5 = 1. Bit 4 is the bus width (1 = 8-bit, 0 = 4-bit, two transfers per byte), bit 3 the addressing scheme (1 = scheme 2), bit 1 the line layout (1 = two lines of 8, 0 = one line of 16), and bit 0 the pin arrangement (1 = B). Bit 2 has no effect. The first such command after reset is always applied.
- R3: In `ST_AWAIT_FSET`, both address commands are ignored: no output changes and `accepted` stays 0.
- R4: In `ST_READY`, a configuration command whose bit 4 equals the stored `if_8bit` changes nothing.
- R5: In `ST_READY`, a configuration command whose bit 4 differs from `if_8bit` updates all four fields together.
- R6: A code with bit 7 = 0 and bit 6 = 1 loads bits 4:0 into `ac` (zero-extended) and sets `ac_is_cg`=1. Bit 5 has no effect.
- R7: A code with bit 7 = 1 loads bits 6:0 into `ac` with `ac_is_cg`=0. Under addressing scheme 1 this happens only for values 0x00 to 0x0F.
- R8: Under addressing scheme 2, a text-memory load is applied only for values 0x00 to 0x07 and 0x40 to 0x47.
- R9: A rejected text-memory load leaves both `ac` and `ac_is_cg` at their prior values.
- R10: A write with `rs` high, and a code with bits 7:5 = 000, change nothing.
- R11: `accepted` is 1 for exactly the one cycle after the clock edge that applied a write. It is 0 after a rejected write and after any cycle without a write. No configuration output changes without it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | One-cycle write strobe |
| rs | input | 1 | Register select; 0 addresses the instruction register |
| code | input | 8 | Instruction code |
| if_8bit | output | 1 | Bus width to the front end: 1 = 8-bit, 0 = 4-bit |
| addr_mode2 | output | 1 | Addressing scheme 2 selected |
| two_line | output | 1 | Two-line layout selected |
| pin_mode_b | output | 1 | Driver pin arrangement B selected |
| ac | output | 7 | Address counter |
| ac_is_cg | output | 1 | Address counter targets glyph memory (1) or text memory (0) |
| accepted | output | 1 | Pulse: previous write took effect |

## Verification
The assertions assume `wr_en` is high for a single cycle per instruction and that `code` and `rs` are stable and known while it is high. The stimulus drives strobes and codes only on the falling edge and returns `wr_en` to 0 between instructions. The address-window check also assumes that the counter changes only through an applied load, so the bench never changes the addressing scheme and loads an address in the same write.

// File: rtl/cdi_pkg.sv
package cdi_pkg;

    typedef enum logic [1:0] {
        CMD_NONE,
        CMD_FSET,
        CMD_CGADDR,
        CMD_DDADDR
    } cmd_e;

    typedef enum logic {
        ST_AWAIT_FSET,
        ST_READY
    } state_e;

    typedef struct packed {
        logic if_8bit;
        logic addr_mode2;
        logic two_line;
        logic pin_b;
    } cfg_t;

endpackage

// File: rtl/cdi_cmd_decode.sv
module cdi_cmd_decode
    import cdi_pkg::*;
#(
    parameter int CODE_W = 8
) (
    input  logic [CODE_W-1:0] code,
    output cmd_e              cmd
);
    localparam int TOP = CODE_W - 1;

    always_comb begin
        if (code[TOP])
            cmd = CMD_DDADDR;
        else if (code[TOP-1])
            cmd = CMD_CGADDR;
        else if (code[TOP-2])
            cmd = CMD_FSET;
        else
            cmd = CMD_NONE;
    end
endmodule

// File: rtl/cdi_dd_window.sv
module cdi_dd_window #(
    parameter int AC_W       = 7,
    parameter int SPAN_ONE   = 16,
    parameter int SPAN_TWO   = 8,
    parameter int LINE2_BASE = 64
) (
    input  logic [AC_W-1:0] addr,
    input  logic            mode2,
    output logic            legal
);
    localparam int LINE2_END = LINE2_BASE + SPAN_TWO;

    logic in_one;
    logic in_first;
    logic in_second;

    always_comb begin
        in_one    = int'(addr) < SPAN_ONE;
        in_first  = int'(addr) < SPAN_TWO;
        in_second = (int'(addr) >= LINE2_BASE) && (int'(addr) < LINE2_END);
        legal     = mode2 ? (in_first || in_second) : in_one;
    end
endmodule

// File: rtl/cdi_ctrl.sv
module cdi_ctrl
    import cdi_pkg::*;
#(
    parameter int CODE_W = 8,
    parameter int AC_W   = 7,
    parameter int CG_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  cmd_e              cmd,
    input  logic [CODE_W-1:0] code,
    input  logic              dd_legal,
    output cfg_t              cfg,
    output logic [AC_W-1:0]   ac,
    output logic              ac_cg,
    output logic              accepted
);
    localparam int BIT_LEN  = 4;
    localparam int BIT_MODE = 3;
    localparam int BIT_LINE = 1;
    localparam int BIT_PIN  = 0;

    state_e          state, state_nxt;
    cfg_t            cfg_nxt;
    logic [AC_W-1:0] ac_nxt;
    logic            ac_cg_nxt;
    logic            take;

    // next-state and next-output logic
    always_comb begin
        state_nxt = state;
        cfg_nxt   = cfg;
        ac_nxt    = ac;
        ac_cg_nxt = ac_cg;
        take      = 1'b0;
        unique case (state)
            ST_AWAIT_FSET: begin
                if (strobe && cmd == CMD_FSET) begin
                    take      = 1'b1;
                    state_nxt = ST_READY;
                end
            end
            ST_READY: begin
                if (strobe) begin
                    unique case (cmd)
                        CMD_FSET:   take = (code[BIT_LEN] != cfg.if_8bit);
                        CMD_CGADDR: take = 1'b1;
                        CMD_DDADDR: take = dd_legal;
                        default:    take = 1'b0;
                    endcase
                end
            end
            default: state_nxt = ST_AWAIT_FSET;
        endcase
        if (take) begin
            unique case (cmd)
                CMD_FSET: begin
                    cfg_nxt.if_8bit    = code[BIT_LEN];
                    cfg_nxt.addr_mode2 = code[BIT_MODE];
                    cfg_nxt.two_line   = code[BIT_LINE];
                    cfg_nxt.pin_b      = code[BIT_PIN];
                end
                CMD_CGADDR: begin
                    ac_nxt    = AC_W'(code[CG_W-1:0]);
                    ac_cg_nxt = 1'b1;
                end
                CMD_DDADDR: begin
                    ac_nxt    = code[AC_W-1:0];
                    ac_cg_nxt = 1'b0;
                end
                default: ;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_AWAIT_FSET;
        else
            state <= state_nxt;
    end

    // output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg      <= '{if_8bit: 1'b1, addr_mode2: 1'b0, two_line: 1'b0, pin_b: 1'b0};
            ac       <= '0;
            ac_cg    <= 1'b0;
            accepted <= 1'b0;
        end else begin
            cfg      <= cfg_nxt;
            ac       <= ac_nxt;
            ac_cg    <= ac_cg_nxt;
            accepted <= take;
        end
    end

    assert_await_blocks_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_AWAIT_FSET && strobe && cmd != CMD_FSET)
        |=> (!accepted && state == ST_AWAIT_FSET));

    assert_locked_fset_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READY && strobe && cmd == CMD_FSET && code[BIT_LEN] == cfg.if_8bit)
        |=> (!accepted && $stable(cfg)));

    assert_first_fset_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_AWAIT_FSET && strobe && cmd == CMD_FSET)
        |=> (accepted && state == ST_READY));

    assert_cfg_needs_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg) |-> accepted);

    assert_idle_no_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> !accepted);
endmodule

// File: rtl/cdisp_instr_decoder.sv
module cdisp_instr_decoder
    import cdi_pkg::*;
#(
    parameter int CODE_W     = 8,
    parameter int AC_W       = 7,
    parameter int CG_W       = 5,
    parameter int SPAN_ONE   = 16,
    parameter int SPAN_TWO   = 8,
    parameter int LINE2_BASE = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic            rs,
    input  logic [CODE_W-1:0] code,
    output logic            if_8bit,
    output logic            addr_mode2,
    output logic            two_line,
    output logic            pin_mode_b,
    output logic [AC_W-1:0] ac,
    output logic            ac_is_cg,
    output logic            accepted
);
    localparam int CG_LIMIT = 1 << CG_W;

    cmd_e cmd;
    cfg_t cfg;
    logic dd_legal;
    logic strobe;

    assign strobe = wr_en && !rs;

    cdi_cmd_decode #(.CODE_W(CODE_W)) u_decode (
        .code (code),
        .cmd  (cmd)
    );

    cdi_dd_window #(
        .AC_W       (AC_W),
        .SPAN_ONE   (SPAN_ONE),
        .SPAN_TWO   (SPAN_TWO),
        .LINE2_BASE (LINE2_BASE)
    ) u_window (
        .addr  (code[AC_W-1:0]),
        .mode2 (cfg.addr_mode2),
        .legal (dd_legal)
    );

    cdi_ctrl #(
        .CODE_W (CODE_W),
        .AC_W   (AC_W),
        .CG_W   (CG_W)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe   (strobe),
        .cmd      (cmd),
        .code     (code),
        .dd_legal (dd_legal),
        .cfg      (cfg),
        .ac       (ac),
        .ac_cg    (ac_is_cg),
        .accepted (accepted)
    );

    assign if_8bit    = cfg.if_8bit;
    assign addr_mode2 = cfg.addr_mode2;
    assign two_line   = cfg.two_line;
    assign pin_mode_b = cfg.pin_b;

    assert_rs_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rs) |=> (!accepted && $stable(ac) && $stable(ac_is_cg)));

    assert_dd_window_R7_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(ac) && !ac_is_cg) |->
            ((!addr_mode2 && int'(ac) < SPAN_ONE) ||
             (addr_mode2 && (int'(ac) < SPAN_TWO ||
                             (int'(ac) >= LINE2_BASE && int'(ac) < LINE2_BASE + SPAN_TWO)))));

    assert_cg_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(ac) && ac_is_cg) |-> (int'(ac) < CG_LIMIT));

    assert_reject_keeps_ac_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !accepted |-> ($stable(ac) && $stable(ac_is_cg)));
endmodule

// File: tb/cdisp_instr_decoder_bench.sv
`timescale 1ns/1ps
module cdisp_instr_decoder_bench;

    typedef struct {
        logic [3:0] cfg;
        logic [6:0] ac;
        logic       cg;
        logic       acc;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rs = 1'b0;
    logic [7:0] code = 8'h00;
    logic       if_8bit, addr_mode2, two_line, pin_mode_b, ac_is_cg, accepted;
    logic [6:0] ac;

    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    exp_t sb_q[$];

    // bench model of the requirements
    logic [3:0] m_cfg = 4'b1000;
    logic [6:0] m_ac = '0;
    logic       m_cg = 1'b0;
    logic       m_ready = 1'b0;

    always #2 clk = ~clk;

    cdisp_instr_decoder u_cdisp_instr_decoder (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .rs         (rs),
        .code       (code),
        .if_8bit    (if_8bit),
        .addr_mode2 (addr_mode2),
        .two_line   (two_line),
        .pin_mode_b (pin_mode_b),
        .ac         (ac),
        .ac_is_cg   (ac_is_cg),
        .accepted   (accepted)
    );

    function automatic bit dd_ok(input logic [6:0] a, input logic mode2);
        if (mode2) return (a < 7'h08) || (a >= 7'h40 && a < 7'h48);
        return a < 7'h10;
    endfunction

    task automatic compare(input exp_t e);
        logic [3:0] got_cfg;
        got_cfg = {if_8bit, addr_mode2, two_line, pin_mode_b};
        checks++;
        if (got_cfg !== e.cfg || ac !== e.ac || ac_is_cg !== e.cg || accepted !== e.acc) begin
            errors++;
            $display("FAIL %s: got cfg=%b ac=%h cg=%b acc=%b, expected cfg=%b ac=%h cg=%b acc=%b",
                     e.tag, got_cfg, ac, ac_is_cg, accepted, e.cfg, e.ac, e.cg, e.acc);
        end
    endtask

    // driver: predict, push, strobe
    task automatic wr(input logic rs_i, input logic [7:0] c, input string tag);
        exp_t e;
        logic acc;
        @(negedge clk);
        acc = 1'b0;
        if (!rs_i) begin
            if (c[7]) begin
                if (m_ready && dd_ok(c[6:0], m_cfg[2])) begin
                    m_ac = c[6:0]; m_cg = 1'b0; acc = 1'b1;
                end
            end else if (c[6]) begin
                if (m_ready) begin
                    m_ac = {2'b00, c[4:0]}; m_cg = 1'b1; acc = 1'b1;
                end
            end else if (c[5]) begin
                if (!m_ready || c[4] != m_cfg[3]) begin
                    m_cfg = {c[4], c[3], c[1], c[0]}; m_ready = 1'b1; acc = 1'b1;
                end
            end
        end
        e.cfg = m_cfg; e.ac = m_ac; e.cg = m_cg; e.acc = acc; e.tag = tag;
        sb_q.push_back(e);
        rs = rs_i; code = c; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; rs = 1'b0;
    endtask

    // monitor: pop and compare after each strobe edge
    initial begin
        forever begin
            @(posedge clk);
            if (wr_en && rst_n) begin
                #1;
                if (sb_q.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL scoreboard: got a write result, expected a queued item");
                end else begin
                    compare(sb_q.pop_front());
                end
            end
        end
    end

    task automatic idle_check(input string tag);
        exp_t e;
        @(posedge clk);
        #1;
        e.cfg = m_cfg; e.ac = m_ac; e.cg = m_cg; e.acc = 1'b0; e.tag = tag;
        compare(e);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #400000;
        checks++; errors++;
        $display("FAIL watchdog: got no end of run, expected completion");
        finish_run();
    end

    initial begin
        exp_t e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        e.cfg = 4'b1000; e.ac = '0; e.cg = 1'b0; e.acc = 1'b0; e.tag = "R1 reset";
        compare(e);

        wr(1'b0, 8'h83, "R3 text addr before config");
        wr(1'b0, 8'h45, "R3 glyph addr before config");
        wr(1'b0, 8'h35, "R2 first config, bit2 ignored");
        idle_check("R11 pulse one cycle");
        wr(1'b0, 8'h3A, "R4 same width locked");
        wr(1'b0, 8'h8F, "R7 mode1 top legal");
        wr(1'b0, 8'h90, "R7 mode1 0x10 rejected");
        wr(1'b0, 8'h7F, "R6 glyph addr, bit5 ignored");
        wr(1'b0, 8'hC0, "R9 rejected keeps glyph target");
        wr(1'b1, 8'h85, "R10 rs high ignored");
        wr(1'b0, 8'h05, "R10 unknown code ignored");
        wr(1'b0, 8'h80, "R7 mode1 zero legal");
        wr(1'b0, 8'h2A, "R5 width change reconfig");
        wr(1'b0, 8'hC7, "R8 mode2 0x47 legal");
        wr(1'b0, 8'hC8, "R8 mode2 0x48 rejected");
        wr(1'b0, 8'h88, "R8 mode2 0x08 rejected");
        wr(1'b0, 8'h87, "R8 mode2 0x07 legal");
        wr(1'b0, 8'h8F, "R9 mode2 0x0F rejected");
        wr(1'b0, 8'hC0, "R8 mode2 0x40 legal");
        wr(1'b0, 8'h2F, "R4 same width 4-bit locked");
        wr(1'b0, 8'h3C, "R5 width change back");
        wr(1'b0, 8'h40, "R6 glyph addr zero");
        idle_check("R11 no write no pulse");
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule